// File: doc/BRIEF.md
# Routed Level Interrupt Aggregator

This block gathers nine level-sensitive interrupt inputs and presents them on three upstream request lines. Each input is resynchronised to the block clock and corrected for a programmable polarity. The resulting active level is latched as a pending flag in the register of every request line. Each request line owns a 32-bit register that pairs a field of per-source enables with a field of per-source pending flags. A line raises its request while any source is both enabled and pending in that register.

Software reaches the polarity register and the three line registers through a plain synchronous read/write port. Pending flags are acknowledged by writing ones to them, so a single write can update the enables of a line, acknowledge any subset of its pending flags, or do both at once. Because all sources are level-sensitive, a pending flag whose source is still active is set again, and that set wins over any acknowledge arriving in the same cycle.

Top module: `irq_route_agg`

## Requirements
- R1: After synchronous reset every register reads as zero, every request output is low, and the input synchronisers hold the inactive level that matches the reset polarity, so no pending flag sets spontaneously.
- R2: The polarity register sits at byte offset 0x0 and uses bits 8:0. Bit n = 1 makes source n active when high; bit n = 0 makes it active when low.
- R3: The register of request line n sits at byte offset 0x4 + 4*n. Its bits 8:0 are enables: bit n = 1 routes source n to that line, and bit n = 0 masks it. A write replaces all nine enables.
- R4: Bits 24:16 of each line register are pending flags, with bit 16+n belonging to source n. A flag sets on every clock where its corrected source is active, in all three line registers, whatever the enables. It stays set after the source goes inactive.
- R5: Writing 1 to pending bit 16+n of a line register clears that flag in that line only. Writing 0 leaves it as it was.
- R6: If a source is still active in the cycle an acknowledge for it is written, its pending flag stays set. This holds even when the same write clears its enable.
- R7: Request output n is a registered, active-high OR over all sources of (enable AND pending) in line register n. A source change driven before clock edge k is seen in the pending flags after edge k+2 and at the request output after edge k+3. An enable write or acknowledge at edge k shows at the output after edge k+1.
- R8: Writing 0x01FF0000 to a line register whose sources are inactive leaves that register reading zero and its request low.
- R9: Reads of unused bits, of offsets above 0xC and of offsets not a multiple of four return zero. Writes to such offsets and to unused bits change nothing.
- R10: Read data is registered. The value of the register addressed while the read strobe is high appears on the read data port after that clock edge, and the port reads zero after any edge where the read strobe was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_raw | input | 9 | Raw asynchronous interrupt inputs |
| irq_out | output | 3 | Active-high request lines, one per line register |

## Verification
The bench goes after the collision between an acknowledge and a still-active source. A design that let the clear win would drop a live interrupt, and the bench sees this as a pending flag missing on read-back. It writes enables with zeros in the pending field to catch a design that treats those zeros as clears and loses pending state. It also checks that pending flags set in lines whose enables are off, so a design that gated the set with the enable would fail on read-back of a masked line. Output timing is sampled at the exact edge, which exposes a missing or extra synchroniser stage. Writes to misaligned offsets and to unused bits check for aliasing into live registers.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    parameter int NUM_SRC    = 9;
    parameter int NUM_LINE   = 3;
    parameter int DATA_W     = 32;
    parameter int ADDR_W     = 4;
    parameter int PEND_LSB   = 16;

    localparam int LINE_IDX_W = (NUM_LINE > 1) ? $clog2(NUM_LINE) : 1;
    localparam int WORD_IDX_W = ADDR_W - 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_POL  = 2'd1,
        REG_LINE = 2'd2
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [LINE_IDX_W-1:0] line;
    } bus_dec_t;

    typedef struct packed {
        src_vec_t en;
        src_vec_t pend;
    } line_state_t;

    function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        int unsigned w;
        d.kind = REG_NONE;
        d.line = '0;
        w = int'(a[ADDR_W-1:2]);
        if (a[1:0] == 2'b00) begin
            if (w == 0) begin
                d.kind = REG_POL;
            end else if (w <= NUM_LINE) begin
                d.kind = REG_LINE;
                d.line = LINE_IDX_W'(w - 1);
            end
        end
        return d;
    endfunction

    function automatic word_t pack_line(input line_state_t s);
        word_t w;
        w = '0;
        w[NUM_SRC-1:0]            = s.en;
        w[PEND_LSB +: NUM_SRC]    = s.pend;
        return w;
    endfunction

    function automatic word_t pack_pol(input src_vec_t p);
        word_t w;
        w = '0;
        w[NUM_SRC-1:0] = p;
        return w;
    endfunction

    function automatic src_vec_t ack_field(input word_t w);
        return w[PEND_LSB +: NUM_SRC];
    endfunction

    function automatic src_vec_t en_field(input word_t w);
        return w[NUM_SRC-1:0];
    endfunction

endpackage

// File: rtl/irq_src_front.sv
module irq_src_front
    import irq_route_pkg::*;
#(
    parameter src_vec_t POL_RST = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t raw,
    input  src_vec_t pol,
    output src_vec_t active
);

    src_vec_t sync1_q;
    src_vec_t sync2_q;

    // Two-flop resynchroniser; reset to the idle level of the reset polarity
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= ~POL_RST;
            sync2_q <= ~POL_RST;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
        end
    end

    // Polarity correction: a source is active when its level equals its polarity bit
    always_comb begin
        active = ~(sync2_q ^ pol);
    end

endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_sel,
    input  word_t       wdata,
    input  src_vec_t    active,
    output line_state_t state,
    output logic        req
);

    line_state_t st_q;
    line_state_t st_d;
    src_vec_t    clr_mask;

    always_comb begin
        clr_mask  = wr_sel ? ack_field(wdata) : '0;
        st_d.en   = wr_sel ? en_field(wdata) : st_q.en;
        // acknowledge first, then a live source sets the flag again
        st_d.pend = (st_q.pend & ~clr_mask) | active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            req  <= 1'b0;
        end else begin
            st_q <= st_d;
            req  <= |(st_q.en & st_q.pend);
        end
    end

    assign state = st_q;

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (|active) |=> ((st_q.pend & $past(active)) == $past(active)));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> ((st_q.pend & $past(ack_field(wdata) & ~active)) == '0));

    assert_hold_pend_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> (st_q.pend == ($past(st_q.pend) | $past(active))));

    assert_en_write_R3: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> (st_q.en == $past(en_field(wdata))));

    assert_en_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(st_q.en));

endmodule

// File: rtl/irq_route_agg.sv
module irq_route_agg
    import irq_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   src_raw,
    output logic [NUM_LINE-1:0]  irq_out
);

    localparam src_vec_t POL_RST = '0;

    bus_dec_t    dec;
    src_vec_t    pol_q;
    src_vec_t    active;
    line_state_t line_st [NUM_LINE];
    word_t       rd_word;
    word_t       rdata_q;

    always_comb begin
        dec = decode_addr(bus_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= POL_RST;
        end else if (bus_wr && dec.kind == REG_POL) begin
            pol_q <= en_field(bus_wdata);
        end
    end

    irq_src_front #(
        .POL_RST (POL_RST)
    ) front_i (
        .clk    (clk),
        .rst    (rst),
        .raw    (src_raw),
        .pol    (pol_q),
        .active (active)
    );

    for (genvar g = 0; g < NUM_LINE; g++) begin : g_line
        logic sel;
        assign sel = bus_wr && (dec.kind == REG_LINE) &&
                     (dec.line == LINE_IDX_W'(g));
        irq_line_ctl line_i (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (sel),
            .wdata  (bus_wdata),
            .active (active),
            .state  (line_st[g]),
            .req    (irq_out[g])
        );
    end

    always_comb begin
        rd_word = '0;
        case (dec.kind)
            REG_POL:  rd_word = pack_pol(pol_q);
            REG_LINE: rd_word = pack_line(line_st[dec.line]);
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= bus_rd ? rd_word : '0;
        end
    end

    assign bus_rdata = rdata_q;

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.kind == REG_NONE) |=> (bus_rdata == '0));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

    assert_pol_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.kind == REG_POL) |=> (pol_q == $past(en_field(bus_wdata))));

    assert_pol_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.kind == REG_NONE) |=> $stable(pol_q));

endmodule

// File: tb/irq_route_agg_tb_top.sv
`timescale 1ns/1ps
module irq_route_agg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  src_raw = 9'h1FF;
    logic [2:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_agg dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_raw   (src_raw),
        .irq_out   (irq_out)
    );

    // Monitor: a read strobe seen at an edge yields data before the next falling edge
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R10 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Driver: issues a read and queues the value the requirements predict
    task automatic rd_expect(input logic [3:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic chk_irq(input logic [2:0] e, input string t);
        checks++;
        if (irq_out !== e) begin
            failures++;
            $display("FAIL %s irq_out actual=%b expected=%b", t, irq_out, e);
        end
    endtask

    task automatic chk_rdata_zero(input string t);
        checks++;
        if (bus_rdata !== 32'h0) begin
            failures++;
            $display("FAIL %s idle rdata actual=%h expected=00000000", t, bus_rdata);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog req=all actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);

        // R1: reset state
        chk_irq(3'b000, "R1");
        rd_expect(4'h0, 32'h0, "R1");
        rd_expect(4'h4, 32'h0, "R1");
        rd_expect(4'h8, 32'h0, "R1");
        rd_expect(4'hC, 32'h0, "R1");
        chk_irq(3'b000, "R1");

        // R2/R4: all active-high, then drop sources; flags set in every line
        wr(4'h0, 32'h0000_01FF);
        src_raw = 9'h000;
        tick(4);
        rd_expect(4'h0, 32'h0000_01FF, "R2");
        rd_expect(4'h4, 32'h01FF_0000, "R4");
        wr(4'h8, 32'h0000_01FF);
        tick(1);
        chk_irq(3'b010, "R7");
        rd_expect(4'h8, 32'h01FF_01FF, "R5");

        // R8: full clear of every line
        wr(4'h4, 32'h01FF_0000);
        wr(4'h8, 32'h01FF_0000);
        wr(4'hC, 32'h01FF_0000);
        tick(1);
        chk_irq(3'b000, "R8");
        rd_expect(4'h4, 32'h0, "R8");
        rd_expect(4'h8, 32'h0, "R8");
        rd_expect(4'hC, 32'h0, "R8");

        // R3/R7: route sources 0 and 2 to line 0, check latency
        wr(4'h4, 32'h0000_0005);
        src_raw = 9'h001;
        tick(3);
        chk_irq(3'b000, "R7");
        tick(1);
        chk_irq(3'b001, "R7");
        rd_expect(4'h8, 32'h0001_0000, "R4");
        rd_expect(4'h4, 32'h0001_0005, "R3");

        // R6: acknowledge while the source is still active
        wr(4'h4, 32'h0001_0005);
        rd_expect(4'h4, 32'h0001_0005, "R6");
        chk_irq(3'b001, "R6");

        // R4 sticky, then R5 acknowledge on one line only
        src_raw = 9'h000;
        tick(4);
        rd_expect(4'h4, 32'h0001_0005, "R4");
        wr(4'h4, 32'h0001_0005);
        chk_irq(3'b001, "R7");
        tick(1);
        chk_irq(3'b000, "R5");
        rd_expect(4'h4, 32'h0000_0005, "R5");
        rd_expect(4'h8, 32'h0001_0000, "R5");

        // R3 masking: source 4 active but enabled nowhere
        src_raw = 9'h010;
        tick(5);
        chk_irq(3'b000, "R3");
        wr(4'hC, 32'h0000_0010);
        tick(1);
        chk_irq(3'b100, "R3");
        rd_expect(4'hC, 32'h0011_0010, "R5");
        // R6: disable and acknowledge together while source still active
        wr(4'hC, 32'h0010_0000);
        tick(1);
        chk_irq(3'b000, "R6");
        rd_expect(4'hC, 32'h0011_0000, "R6");
        src_raw = 9'h000;
        tick(4);
        wr(4'hC, 32'h01FF_0000);
        rd_expect(4'hC, 32'h0, "R8");

        // R2: source 3 active-low
        wr(4'h0, 32'h0000_01F7);
        tick(3);
        rd_expect(4'h4, 32'h0018_0005, "R2");
        src_raw = 9'h008;
        tick(4);
        wr(4'h4, 32'h0018_0005);
        rd_expect(4'h4, 32'h0000_0005, "R2");
        wr(4'h8, 32'h0000_0008);
        tick(1);
        chk_irq(3'b010, "R2");
        wr(4'h8, 32'h01FF_0000);
        tick(1);
        chk_irq(3'b000, "R8");
        rd_expect(4'h8, 32'h0, "R8");

        // R9: unmapped offsets and unused bits
        wr(4'h3, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd_expect(4'h1, 32'h0, "R9");
        rd_expect(4'h2, 32'h0, "R9");
        rd_expect(4'h0, 32'h0000_01F7, "R9");
        rd_expect(4'h4, 32'h0000_0005, "R9");
        wr(4'h4, 32'hFE00_FE05);
        rd_expect(4'h4, 32'h0000_0005, "R9");
        wr(4'h0, 32'hFFFF_FFF7);
        rd_expect(4'h0, 32'h0000_01F7, "R9");

        // R10: read data returns to zero once the strobe drops
        tick(1);
        chk_rdata_zero("R10");
        tick(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule